// File: doc/BRIEF.md
# Saturating Motion Delta Accumulator

This block collects per-frame signed displacement increments for two axes into internal accumulators that are wider than the 8-bit readout. A host drains the collected motion one byte at a time through per-axis read strobes. Each read reports the accumulator value clamped to the 8-bit two's complement range, and removes exactly the reported amount. A large backlog therefore survives several reads instead of being lost in one. A motion flag and an active-low motion pin show that data is waiting. An overflow flag records when an accumulator hit its own limit and path data was lost.

Increments arrive on a valid/ready stream. The block accepts a beat on every cycle except the cycle of a clear-write. In that cycle `inc_ready` is low, and the source must hold its beat until the next cycle. A resolution select picks the fine setting (increments taken whole) or the coarse setting (increments halved, with the accumulator range halved too). The control inputs (read strobes, clear-write, resolution) are plain single-cycle level pins.

Top module: `delta_accum`

## Requirements
- R1: Each axis readout is the accumulator clamped to the 8-bit two's complement range. Values above +127 read as 0x7F, values below -128 read as 0x80, and values in range read as their low 8 bits.
- R2: An accepted beat (`inc_valid` and `inc_ready` both high) adds its signed increment to each axis. With `res_hi`=1 the increment is added as is. With `res_hi`=0 it is first shifted right arithmetically by one (rounding toward minus infinity, so -1 stays -1).
- R3: Accumulators saturate. With `res_hi`=1 the range is -4096..+4095, and with `res_hi`=0 it is -2048..+2047. An update that would leave the range is held at the limit, and `ovf` is high from the next cycle.
- R4: A read strobe on an axis subtracts that axis's current readout at the same clock edge. An increment accepted in that cycle is also applied, so neither event is lost.
- R5: `mot` is high exactly when either accumulator is nonzero, and `motion_n` is its inverse. After reset both accumulators are zero, `mot` and `ovf` are low and `motion_n` is high.
- R6: `ovf` goes low after a cycle with at least one read, provided no accumulator sits at a range limit after that cycle's update. Without a read, `ovf` holds.
- R7: A clear-write zeroes both accumulators and `ovf` in one cycle. It has priority over the reads and over any increment of that cycle.
- R8: A backlog drains in a computable number of reads. The value -4096 at fine resolution takes 32 reads, -2048 at coarse resolution takes 16, and +4095 takes 33 (readouts of 0x7F, ending with 31).
- R9: `inc_ready` is low exactly in a cycle where `clr_wr` is high, and high otherwise. A beat offered while `inc_ready` is low is not taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| inc_valid | input | 1 | Increment beat valid |
| inc_ready | output | 1 | Increment beat accepted this cycle |
| inc_dx | input | 8 | Signed X increment |
| inc_dy | input | 8 | Signed Y increment |
| rd_y | input | 1 | Read strobe, Y readout |
| rd_x | input | 1 | Read strobe, X readout |
| clr_wr | input | 1 | Clear-write to motion register (data not stored) |
| res_hi | input | 1 | 1 = fine resolution, 0 = coarse (halved) |
| delta_y | output | 8 | Saturated Y readout |
| delta_x | output | 8 | Saturated X readout |
| mot | output | 1 | Motion pending flag |
| ovf | output | 1 | Overflow flag |
| motion_n | output | 1 | Motion pin, active low |

## Verification
A read drain and an accepted increment can hit the same axis in the same cycle. So can a clear-write and a valid beat with reads. The bench provokes both in a long pseudo-random stretch. It mixes strobes, beats and clear-writes freely, and adds a directed step that reads and adds at once. After every edge it compares both readouts and all flags with an arithmetic model. The model subtracts the old readout and adds the scaled increment in one update, and it makes the clear win outright, with `inc_ready` checked low in that cycle.

// File: rtl/delta_accum_pkg.sv
package delta_accum_pkg;
  // Axis indices used for the per-axis arrays in the top module.
  localparam int AX_Y = 0;
  localparam int AX_X = 1;
  localparam int N_AXES = 2;

  typedef enum logic {
    RES_COARSE = 1'b0,
    RES_FINE   = 1'b1
  } res_e;
endpackage

// File: rtl/delta_axis.sv
module delta_axis #(
  parameter int INC_W = 8,
  parameter int ACC_W = 13,
  parameter int OUT_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    res_hi,
  input  logic                    take,
  input  logic signed [INC_W-1:0] inc,
  input  logic                    rd,
  output logic [OUT_W-1:0]        rdout,
  output logic                    nonzero,
  output logic                    ovf_evt,
  output logic                    at_lim
);
  localparam int SW     = ACC_W + 2;
  localparam int FINE_HI   = 2**(ACC_W-1) - 1;
  localparam int FINE_LO   = -(2**(ACC_W-1));
  localparam int COARSE_HI = 2**(ACC_W-2) - 1;
  localparam int COARSE_LO = -(2**(ACC_W-2));
  localparam int OUT_HI = 2**(OUT_W-1) - 1;
  localparam int OUT_LO = -(2**(OUT_W-1));

  logic signed [ACC_W-1:0] acc_q;
  logic signed [SW-1:0]    acc_w, lim_hi, lim_lo, inc_s, drain, sum, nxt;
  logic signed [OUT_W-1:0] sat_out;

  assign acc_w  = SW'(acc_q);
  assign lim_hi = res_hi ? SW'(FINE_HI) : SW'(COARSE_HI);
  assign lim_lo = res_hi ? SW'(FINE_LO) : SW'(COARSE_LO);

  // Readout clamp to the 8-bit two's complement range.
  always_comb begin
    if (acc_w > SW'(OUT_HI))      sat_out = OUT_W'(OUT_HI);
    else if (acc_w < SW'(OUT_LO)) sat_out = OUT_W'(OUT_LO);
    else                          sat_out = acc_q[OUT_W-1:0];
  end
  assign rdout = sat_out;

  // Increment scaling: coarse setting halves with arithmetic shift.
  always_comb begin
    if (!take)       inc_s = '0;
    else if (res_hi) inc_s = SW'(inc);
    else             inc_s = SW'(inc >>> 1);
  end

  assign drain = rd ? SW'(sat_out) : '0;
  assign sum   = acc_w - drain + inc_s;

  // Saturate the update at the resolution-dependent limits.
  always_comb begin
    ovf_evt = 1'b0;
    nxt     = sum;
    if (sum > lim_hi) begin
      nxt     = lim_hi;
      ovf_evt = 1'b1;
    end else if (sum < lim_lo) begin
      nxt     = lim_lo;
      ovf_evt = 1'b1;
    end
  end
  assign at_lim  = (nxt == lim_hi) || (nxt == lim_lo);
  assign nonzero = |acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   acc_q <= '0;
    else if (clr) acc_q <= '0;
    else          acc_q <= ACC_W'(nxt);
  end

  // R4: a pure read removes exactly the value it reported.
  a_r4_read_drains: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !clr && !take) |=> (acc_w == $past(acc_w) - SW'($past(sat_out))));

  // R3: at coarse resolution the accumulator stays inside the halved range.
  a_r3_coarse_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (!res_hi && $past(!res_hi)) |-> (acc_w <= SW'(COARSE_HI) && acc_w >= SW'(COARSE_LO)));

  // R7: clear empties the axis.
  a_r7_axis_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !nonzero);
endmodule

// File: rtl/delta_ovf_flag.sv
module delta_ovf_flag #(
  parameter int N_AX = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            any_rd,
  input  logic [N_AX-1:0] evt,
  input  logic [N_AX-1:0] lim,
  output logic            ovf
);
  logic ovf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 ovf_q <= 1'b0;
    else if (clr)               ovf_q <= 1'b0;
    else if (|evt)              ovf_q <= 1'b1;
    else if (any_rd && !(|lim)) ovf_q <= 1'b0;
  end
  assign ovf = ovf_q;

  a_r3_ovf_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && |evt) |=> ovf);

  a_r6_ovf_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !clr && !any_rd) |=> ovf);

  a_r6_ovf_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && any_rd && !(|lim)) |=> !ovf);

  a_r7_ovf_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !ovf);
endmodule

// File: rtl/delta_accum.sv
module delta_accum
  import delta_accum_pkg::*;
#(
  parameter int INC_W = 8,
  parameter int ACC_W = 13,
  parameter int OUT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_valid,
  output logic             inc_ready,
  input  logic [INC_W-1:0] inc_dx,
  input  logic [INC_W-1:0] inc_dy,
  input  logic             rd_y,
  input  logic             rd_x,
  input  logic             clr_wr,
  input  logic             res_hi,
  output logic [OUT_W-1:0] delta_y,
  output logic [OUT_W-1:0] delta_x,
  output logic             mot,
  output logic             ovf,
  output logic             motion_n
);
  logic                    take;
  logic [INC_W-1:0]        inc_a  [N_AXES];
  logic [OUT_W-1:0]        out_a  [N_AXES];
  logic [N_AXES-1:0]       rd_a, nz_a, evt_a, lim_a;

  // The only cycle without room for a beat is a clear-write.
  assign inc_ready = !clr_wr;
  assign take      = inc_valid && inc_ready;

  assign inc_a[AX_Y] = inc_dy;
  assign inc_a[AX_X] = inc_dx;
  assign rd_a[AX_Y]  = rd_y;
  assign rd_a[AX_X]  = rd_x;

  for (genvar g = 0; g < N_AXES; g++) begin : g_axis
    delta_axis #(
      .INC_W (INC_W),
      .ACC_W (ACC_W),
      .OUT_W (OUT_W)
    ) axis_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr_wr),
      .res_hi  (res_hi),
      .take    (take),
      .inc     (signed'(inc_a[g])),
      .rd      (rd_a[g]),
      .rdout   (out_a[g]),
      .nonzero (nz_a[g]),
      .ovf_evt (evt_a[g]),
      .at_lim  (lim_a[g])
    );
  end

  delta_ovf_flag #(.N_AX(N_AXES)) ovf_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr_wr),
    .any_rd (|rd_a),
    .evt    (evt_a),
    .lim    (lim_a),
    .ovf    (ovf)
  );

  assign delta_y  = out_a[AX_Y];
  assign delta_x  = out_a[AX_X];
  assign mot      = |nz_a;
  assign motion_n = !mot;

  // R5: the motion flag agrees with the clamped readouts.
  a_r5_mot_readout: assert property (@(posedge clk) disable iff (!rst_n)
    mot == ((delta_x != '0) || (delta_y != '0)));

  // R7: a clear-write leaves no motion pending.
  a_r7_no_motion: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> (!mot && motion_n));
endmodule

// File: tb/delta_accum_tb_top.sv
module delta_accum_tb_top;
  localparam time CLK_P = 20ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       inc_valid = 1'b0, inc_ready;
  logic [7:0] inc_dx = '0, inc_dy = '0;
  logic       rd_y = 1'b0, rd_x = 1'b0, clr_wr = 1'b0, res_hi = 1'b1;
  logic [7:0] delta_y, delta_x;
  logic       mot, ovf, motion_n;

  int n_tests = 0, n_fail = 0;
  int ax = 0, ay = 0;
  bit eovf = 0;

  always #(CLK_P/2) clk = ~clk;

  delta_accum dut_i (
    .clk(clk), .rst_n(rst_n), .inc_valid(inc_valid), .inc_ready(inc_ready),
    .inc_dx(inc_dx), .inc_dy(inc_dy), .rd_y(rd_y), .rd_x(rd_x), .clr_wr(clr_wr),
    .res_hi(res_hi), .delta_y(delta_y), .delta_x(delta_x), .mot(mot), .ovf(ovf),
    .motion_n(motion_n)
  );

  function automatic int sat8(input int v);
    if (v > 127) return 127;
    if (v < -128) return -128;
    return v;
  endfunction

  function automatic void upd(inout int a, input bit tk, input int d, input bit rd,
                              input bit res, output bit evt, output bit lim);
    int hi = res ? 4095 : 2047;
    int lo = -hi - 1;
    int s = a - (rd ? sat8(a) : 0) + (tk ? (res ? d : (d >>> 1)) : 0);
    evt = 0;
    if (s > hi) begin s = hi; evt = 1; end
    if (s < lo) begin s = lo; evt = 1; end
    lim = (s == hi) || (s == lo);
    a = s;
  endfunction

  task automatic check_out(input string tag);
    bit ok;
    n_tests++;
    ok = (delta_x == 8'(sat8(ax))) && (delta_y == 8'(sat8(ay))) &&
         (mot == ((ax != 0) || (ay != 0))) && (motion_n == !mot) && (ovf == eovf);
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: dx=%02h/%02h dy=%02h/%02h mot=%0b/%0b pin=%0b ovf=%0b/%0b",
               tag, delta_x, 8'(sat8(ax)), delta_y, 8'(sat8(ay)), mot,
               (ax != 0) || (ay != 0), motion_n, ovf, eovf);
    end
  endtask

  // One cycle: drive at negedge, update model, check after the edge.
  task automatic step(input bit vld, input int dx, input int dy, input bit rx,
                      input bit ry, input bit clr, input bit res, input string tag);
    bit ex, ey, lx, ly, tk;
    inc_valid = vld; inc_dx = 8'(dx); inc_dy = 8'(dy);
    rd_x = rx; rd_y = ry; clr_wr = clr; res_hi = res;
    #1;
    n_tests++;
    if (inc_ready != !clr) begin
      n_fail++;
      $display("FAIL R9: inc_ready=%0b expected %0b", inc_ready, !clr);
    end
    tk = vld && !clr;
    if (clr) begin
      ax = 0; ay = 0; eovf = 0;
    end else begin
      upd(ax, tk, dx, rx, res, ex, lx);
      upd(ay, tk, dy, ry, res, ey, ly);
      if (ex || ey) eovf = 1;
      else if ((rx || ry) && !(lx || ly)) eovf = 0;
    end
    @(posedge clk);
    @(negedge clk);
    inc_valid = 0; rd_x = 0; rd_y = 0; clr_wr = 0;
    check_out(tag);
  endtask

  task automatic drain_x(input bit res, input int exp_n, input string tag);
    int n = 0;
    while (mot && n < 100) begin
      step(0, 0, 0, 1, 0, 0, res, tag);
      n++;
    end
    n_tests++;
    if (n != exp_n) begin
      n_fail++;
      $display("FAIL %s: drain reads=%0d expected %0d", tag, n, exp_n);
    end
  endtask

  task automatic drain_y(input bit res, input int exp_n, input string tag);
    int n = 0;
    while (mot && n < 100) begin
      step(0, 0, 0, 0, 1, 0, res, tag);
      n++;
    end
    n_tests++;
    if (n != exp_n) begin
      n_fail++;
      $display("FAIL %s: drain reads=%0d expected %0d", tag, n, exp_n);
    end
  endtask

  initial begin : watchdog
    #(CLK_P * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    logic [31:0] lfsr = 32'hACE1_2468;
    repeat (3) @(negedge clk);
    check_out("R5 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_out("R5 after reset release");

    // R1 R2: every increment value at both resolutions, then read both axes.
    for (int r = 0; r < 2; r++) begin
      for (int v = -128; v < 128; v++) begin
        step(0, 0, 0, 0, 0, 1, r[0], "R7 clear");
        step(1, v, -v - 1, 0, 0, 0, r[0], "R2 increment");
        step(0, 0, 0, 1, 1, 0, r[0], "R4 read both");
      end
    end

    // R1 readout clamp with a large value, R4 read and add in one cycle.
    step(0, 0, 0, 0, 0, 1, 1, "R7 clear");
    for (int i = 0; i < 3; i++) step(1, 100, -100, 0, 0, 0, 1, "R1 clamp build");
    step(1, 50, -50, 1, 1, 0, 1, "R4 read with add");

    // R3 R8: fine positive limit, 33 reads to drain.
    step(0, 0, 0, 0, 0, 1, 1, "R7 clear");
    for (int i = 0; i < 34; i++) step(1, 127, 0, 0, 0, 0, 1, "R3 fine fill");
    drain_x(1, (4095 + 126) / 127, "R8 fine positive drain");
    // R6: after the drain no limit remains, overflow is gone.
    step(0, 0, 0, 0, 0, 0, 1, "R6 idle after drain");

    // R3 R8: fine negative limit, 32 reads.
    step(0, 0, 0, 0, 0, 1, 1, "R7 clear");
    for (int i = 0; i < 34; i++) step(1, 0, -128, 0, 0, 0, 1, "R3 fine neg fill");
    step(0, 0, 0, 0, 0, 0, 1, "R6 hold without read");
    drain_y(1, 4096 / 128, "R8 fine negative drain");

    // R3 R8: coarse limit, 16 reads.
    step(0, 0, 0, 0, 0, 1, 0, "R7 clear");
    for (int i = 0; i < 40; i++) step(1, 0, -128, 0, 0, 0, 0, "R3 coarse fill");
    drain_y(0, 2048 / 128, "R8 coarse drain");

    // R7 R9: clear collides with a beat and reads.
    step(1, 20, 20, 0, 0, 0, 1, "R2 preload");
    step(1, 30, 30, 1, 1, 1, 1, "R7 clear wins");

    // Mixed stretch: reads, beats and clears colliding at random.
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step(lfsr[0] | lfsr[1], $signed(lfsr[15:8]), $signed(lfsr[23:16]),
           lfsr[2] & lfsr[3], lfsr[4] & lfsr[5], (lfsr[30:26] == 5'd0),
           (i / 1000) % 2 == 0, "R4 R6 mixed");
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule